// File: doc/BRIEF.md
# Receive Byte Queue with Hysteretic Flow Control

This block buffers bytes arriving from a serial receiver in a first-in first-out queue of 128 entries and hands them to a host one at a time. It raises a threshold interrupt when enough bytes have piled up for the host to service. It also drives an active-low request-to-send line that tells the far end to pause.

The pause line works with hysteresis. It is released (driven high) only when the occupancy climbs to an upper bound. It is asserted again (driven low) only once the host has drained the queue down to a separate lower bound. Both bounds are independent of the interrupt threshold. While the pause line is high the queue keeps taking bytes until it is completely full.

The three levels come from one of two sources. They can be programmed directly. They can also be picked from a fixed table: the chosen entry is the interrupt threshold, and the entries on either side of it become the hysteresis bounds.

Top module: `rx_fifo_flowctl`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, rd_data is 0, overrun is 0, rx_irq is 0 and rts_n is 1.
- R2: Bytes are read out in the order they were written. A read of a non-empty queue loads rd_data with the oldest byte at that clock edge. An accepted write raises count by one and an accepted read lowers it by one.
- R3: A write while count is 128 is dropped and count stays 128. overrun is 1 for the single cycle after that edge and is 0 otherwise.
- R4: A read while the queue is empty leaves rd_data unchanged and count at 0.
- R5: A read and a write in the same cycle on a queue that is neither empty nor full leave count unchanged and keep the byte order.
- R6: rx_irq is 1 exactly while count is at or above the trigger level. It clears as soon as count falls below that level.
- R7: With auto control active (auto_rts_en=1 and rts_req=1), rts_n goes to 1 at the clock edge where count reaches the upper level or more, and not at the trigger level.
- R8: With auto control active and rts_n at 1, rts_n returns to 0 only at the edge where count falls to the lower level or below. Between the two bounds it holds its value.
- R9: After rts_n goes to 1, writes keep being accepted until count reaches 128.
- R10: rts_n is 1 at every edge after one where rts_req is 0. With auto_rts_en=0, rts_n is the inverse of rts_req, registered. Auto control starts from rts_n=0 when rts_req is asserted.
- R11: With lvl_prog=0, selection k=tbl_sel (a value of 0 is treated as 1) gives a trigger level of k*16, an upper level of (k+1)*16 and a lower level of (k-1)*16.
- R12: With lvl_prog=1, the trigger, upper and lower levels are prog_trig, prog_hi and prog_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 8 | Last byte read |
| lvl_prog | input | 1 | 1 selects programmed levels, 0 selects the fixed table |
| tbl_sel | input | 3 | Table entry used as the trigger level |
| prog_trig | input | 8 | Programmed trigger level |
| prog_hi | input | 8 | Programmed upper hysteresis level |
| prog_lo | input | 8 | Programmed lower hysteresis level |
| auto_rts_en | input | 1 | Enables automatic flow control |
| rts_req | input | 1 | Host request to assert the request-to-send line |
| count | output | 8 | Queue occupancy, 0 to 128 |
| full | output | 1 | Occupancy is 128 |
| empty | output | 1 | Occupancy is 0 |
| overrun | output | 1 | One-cycle pulse after a dropped write |
| rx_irq | output | 1 | Occupancy at or above the trigger level |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
A steady fill to full followed by a steady drain to empty sweeps the occupancy through the trigger level and both hysteresis bounds in each direction. This shows that the interrupt and the pause line react at different levels, and that the pause line holds its value between the bounds. Extra writes at full and extra reads at empty show that dropped operations do not disturb the count or the data. Streams of simultaneous reads and writes show that the count stays put while the data keeps flowing. Long random runs with a bias first toward writing and then toward reading are repeated under programmed levels, under the lowest and highest table entries, and with the request line and the auto enable toggled. These runs separate wrong threshold selection, off-by-one comparisons and lost hysteresis state.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        LVL_TABLE = 1'b0,
        LVL_PROG  = 1'b1
    } lvl_src_e;

    typedef struct packed {
        logic flow_off;
        logic rts_n;
    } rts_st_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          full,
    output logic          empty,
    output logic          overrun
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rdat;
        logic          ovr;
    } store_st_t;

    store_st_t     st_q, st_d;
    logic [DW-1:0] mem [DEPTH];
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        do_wr  = wr_en && (st_q.cnt != CW'(DEPTH));
        do_rd  = rd_en && (st_q.cnt != '0);
        st_d.ovr = wr_en && (st_q.cnt == CW'(DEPTH));
        if (do_wr) begin
            st_d.wptr = ptr_inc(st_q.wptr);
        end
        if (do_rd) begin
            st_d.rdat = mem[st_q.rptr];
            st_d.rptr = ptr_inc(st_q.rptr);
        end
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[st_q.wptr] <= wr_data;
        end
    end

    assign rd_data   = st_q.rdat;
    assign count     = st_q.cnt;
    assign count_nxt = st_d.cnt;
    assign full      = (st_q.cnt == CW'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign overrun   = st_q.ovr;

endmodule

// File: rtl/rxq_levels.sv
module rxq_levels #(
    parameter  int DEPTH = 128,
    parameter  int SEL_W = 3,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int STEP  = DEPTH / (2 ** SEL_W)
) (
    input  rxq_pkg::lvl_src_e lvl_src,
    input  logic [SEL_W-1:0]  tbl_sel,
    input  logic [CW-1:0]     prog_trig,
    input  logic [CW-1:0]     prog_hi,
    input  logic [CW-1:0]     prog_lo,
    output logic [CW-1:0]     trig,
    output logic [CW-1:0]     hi,
    output logic [CW-1:0]     lo
);

    int unsigned k;

    always_comb begin
        k = (tbl_sel == '0) ? 1 : int'(tbl_sel);
        if (lvl_src == rxq_pkg::LVL_PROG) begin
            trig = prog_trig;
            hi   = prog_hi;
            lo   = prog_lo;
        end else begin
            trig = CW'(k * STEP);
            hi   = CW'((k + 1) * STEP);
            lo   = CW'((k - 1) * STEP);
        end
    end

endmodule

// File: rtl/rxq_rts.sv
module rxq_rts #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_en,
    input  logic          rts_req,
    input  logic [CW-1:0] count_nxt,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    output logic          rts_n
);

    rxq_pkg::rts_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!(auto_en && rts_req)) begin
            st_d.flow_off = 1'b0;
        end else if (count_nxt >= hi) begin
            st_d.flow_off = 1'b1;
        end else if (count_nxt <= lo) begin
            st_d.flow_off = 1'b0;
        end
        st_d.rts_n = !rts_req || (auto_en && st_d.flow_off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flow_off <= 1'b0;
            st_q.rts_n    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_n = st_q.rts_n;

endmodule

// File: rtl/rx_fifo_flowctl.sv
module rx_fifo_flowctl #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    parameter  int SEL_W = 3,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    output logic [DW-1:0]    rd_data,
    input  logic             lvl_prog,
    input  logic [SEL_W-1:0] tbl_sel,
    input  logic [CW-1:0]    prog_trig,
    input  logic [CW-1:0]    prog_hi,
    input  logic [CW-1:0]    prog_lo,
    input  logic             auto_rts_en,
    input  logic             rts_req,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output logic             overrun,
    output logic             rx_irq,
    output logic             rts_n
);

    logic [CW-1:0] count_nxt;
    logic [CW-1:0] lvl_trig, lvl_hi, lvl_lo;
    rxq_pkg::lvl_src_e lvl_src;

    assign lvl_src = lvl_prog ? rxq_pkg::LVL_PROG : rxq_pkg::LVL_TABLE;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .count     (count),
        .count_nxt (count_nxt),
        .full      (full),
        .empty     (empty),
        .overrun   (overrun)
    );

    rxq_levels #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_levels (
        .lvl_src   (lvl_src),
        .tbl_sel   (tbl_sel),
        .prog_trig (prog_trig),
        .prog_hi   (prog_hi),
        .prog_lo   (prog_lo),
        .trig      (lvl_trig),
        .hi        (lvl_hi),
        .lo        (lvl_lo)
    );

    rxq_rts #(.CW(CW)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_rts_en),
        .rts_req   (rts_req),
        .count_nxt (count_nxt),
        .hi        (lvl_hi),
        .lo        (lvl_lo),
        .rts_n     (rts_n)
    );

    assign rx_irq = (count >= lvl_trig);

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 128,
    parameter int CW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          empty,
    input logic          overrun,
    input logic          auto_rts_en,
    input logic          rts_req,
    input logic          rts_n,
    input logic [CW-1:0] lvl_hi,
    input logic [CW-1:0] lvl_lo
);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (count == CW'(DEPTH))); // R3

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(full && wr_en)); // R3

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> ($stable(rd_data) && count == '0)); // R4

    AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && wr_en && rd_en) |=> $stable(count)); // R5

    AST_RTS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_rts_en && rts_req) && count >= $past(lvl_hi)) |-> rts_n); // R7

    AST_RTS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_rts_en && rts_req) && count < $past(lvl_hi)
         && count <= $past(lvl_lo)) |-> !rts_n); // R8

    AST_RTS_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_req |=> rts_n); // R10

endmodule

bind rx_fifo_flowctl rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .count       (count),
    .full        (full),
    .empty       (empty),
    .overrun     (overrun),
    .auto_rts_en (auto_rts_en),
    .rts_req     (rts_req),
    .rts_n       (rts_n),
    .lvl_hi      (lvl_hi),
    .lvl_lo      (lvl_lo)
);

// File: tb/rx_fifo_flowctl_tb.sv
module rx_fifo_flowctl_tb;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       lvl_prog = 1'b0;
    logic [2:0] tbl_sel = 3'd2;
    logic [7:0] prog_trig = '0, prog_hi = '0, prog_lo = '0;
    logic       auto_rts_en = 1'b0, rts_req = 1'b0;
    logic [7:0] count;
    logic       full, empty, overrun, rx_irq, rts_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mq [$];
    logic [7:0] exp_rd = '0;
    logic       exp_ovr = 1'b0;
    logic       exp_flow = 1'b0;

    always #10 clk = ~clk;

    rx_fifo_flowctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .lvl_prog(lvl_prog), .tbl_sel(tbl_sel),
        .prog_trig(prog_trig), .prog_hi(prog_hi), .prog_lo(prog_lo),
        .auto_rts_en(auto_rts_en), .rts_req(rts_req), .count(count),
        .full(full), .empty(empty), .overrun(overrun), .rx_irq(rx_irq), .rts_n(rts_n)
    );

    function automatic int lvl(input int which);
        int k;
        if (lvl_prog) begin
            if (which == 0) return int'(prog_trig);
            if (which == 1) return int'(prog_hi);
            return int'(prog_lo);
        end
        k = (tbl_sel == 3'd0) ? 1 : int'(tbl_sel);
        return (k + which * (which == 1 ? 1 : 0) - (which == 2 ? 1 : 0)) * 16;
    endfunction

    function automatic logic exp_rts();
        return !rts_req || (auto_rts_en && exp_flow);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int n;
        n = mq.size();
        chk(tag, "count", int'(count), n);
        chk(tag, "full", int'(full), int'(n == DEPTH));
        chk(tag, "empty", int'(empty), int'(n == 0));
        chk(tag, "rd_data", int'(rd_data), int'(exp_rd));
        chk(tag, "overrun", int'(overrun), int'(exp_ovr));
        chk(tag, "rx_irq", int'(rx_irq), int'(n >= lvl(0)));
        chk(tag, "rts_n", int'(rts_n), int'(exp_rts()));
    endtask

    task automatic model_edge(input bit w, input bit r, input logic [7:0] d);
        int n;
        n = mq.size();
        exp_ovr = w && (n == DEPTH);
        if (r && n > 0) exp_rd = mq.pop_front();
        if (w && n < DEPTH) mq.push_back(d);
        n = mq.size();
        if (!(auto_rts_en && rts_req)) exp_flow = 1'b0;
        else if (n >= lvl(1)) exp_flow = 1'b1;
        else if (n <= lvl(2)) exp_flow = 1'b0;
    endtask

    task automatic step(input bit w, input bit r, input logic [7:0] d, input string tag);
        wr_en = w;
        rd_en = r;
        wr_data = d;
        @(posedge clk);
        model_edge(w, r, d);
        #5;
        check_all(tag);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic rand_run(input int n, input int wr_pct, input int rd_pct, input string tag);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 100) < wr_pct, ($urandom % 100) < rd_pct,
                 8'($urandom), tag);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1: reset state
        check_all("R1");
        @(negedge clk);

        // table entry 2: trigger 32, upper 48, lower 16 (R11)
        lvl_prog = 1'b0;
        tbl_sel = 3'd2;
        auto_rts_en = 1'b1;
        rts_req = 1'b1;
        step(1'b0, 1'b0, 8'h00, "R10");
        // R6/R7: rts stays low through the trigger level, goes high at 48
        for (int i = 0; i < 47; i++) step(1'b1, 1'b0, 8'(i + 1), "R7");
        chk("R6", "irq above trigger", int'(rx_irq), 1);
        chk("R7", "rts low below upper", int'(rts_n), 0);
        step(1'b1, 1'b0, 8'd48, "R7");
        chk("R7", "rts high at upper", int'(rts_n), 1);
        // R9: keeps accepting to full
        for (int i = 48; i < DEPTH; i++) step(1'b1, 1'b0, 8'(i + 1), "R9");
        chk("R9", "count at full", int'(count), DEPTH);
        // R3: writes at full dropped
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'hEE, "R3");
        step(1'b0, 1'b0, 8'h00, "R3");
        chk("R3", "overrun clears", int'(overrun), 0);
        // R8/R2: drain; rts holds high until count 16
        for (int i = 0; i < DEPTH - 17; i++) step(1'b0, 1'b1, 8'h00, "R8");
        chk("R8", "rts held at 17", int'(rts_n), 1);
        step(1'b0, 1'b1, 8'h00, "R8");
        chk("R8", "rts low at 16", int'(rts_n), 0);
        chk("R2", "order byte", int'(rd_data), 112);
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 8'h00, "R2");
        // R4: reads on empty
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'h00, "R4");
        chk("R4", "last byte kept", int'(rd_data), 128);

        // R5: simultaneous read and write
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 8'(8'hA0 + i), "R5");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 8'(8'hC0 + i), "R5");
        chk("R5", "count held", int'(count), 10);

        // R10: request off and auto disabled
        rts_req = 1'b0;
        step(1'b0, 1'b0, 8'h00, "R10");
        auto_rts_en = 1'b0;
        rts_req = 1'b1;
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 8'(i), "R10");
        chk("R10", "manual rts low", int'(rts_n), 0);
        auto_rts_en = 1'b1;
        rand_run(400, 20, 80, "R10");

        // R12: programmed levels
        lvl_prog = 1'b1;
        prog_trig = 8'd5;
        prog_hi = 8'd100;
        prog_lo = 8'd90;
        rand_run(1500, 75, 25, "R12");
        rand_run(1500, 25, 75, "R12");
        prog_trig = 8'd120;
        prog_hi = 8'd64;
        prog_lo = 8'd10;
        rand_run(1000, 70, 30, "R12");
        rand_run(1000, 30, 70, "R12");

        // R11: extreme table entries, with request toggling
        lvl_prog = 1'b0;
        tbl_sel = 3'd7;
        rand_run(1500, 80, 25, "R11");
        rand_run(1500, 25, 80, "R11");
        tbl_sel = 3'd0;
        for (int j = 0; j < 6; j++) begin
            rts_req = j[0];
            rand_run(300, 60, 40, "R11");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule